// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial bus in front of a 256-byte storage array. Both bus lines are oversampled on the system clock and passed through a synchroniser and a pulse filter. Start and stop conditions are then picked out of the filtered lines. A device-select byte is compared with a fixed family code and three strap inputs. An internal 8-bit word pointer is used for byte writes, page writes and sequential reads. The block drives the shared data line only by pulling it low, through an output-enable pin.

Every write transaction that delivers at least one data byte ends, at its stop condition, in a timed programming window. During that window the block ignores the bus completely. A protect input keeps the upper half of the array from changing. The array is a plain register file, and a down-counter stands in for programming time.

The control is one state machine. ST_IDLE waits for a start. ST_DEV shifts in the select byte. It goes to ST_DEV_ACK on a match and to ST_SKIP otherwise. ST_DEV_ACK leads to ST_WADR for a write or to ST_RDAT for a read. ST_WADR takes the word pointer and passes through ST_WADR_ACK. ST_WDAT takes data bytes and passes through ST_WDAT_ACK after each one. ST_RDAT shifts a byte out and moves to ST_RACK. ST_RACK returns to ST_RDAT on a host acknowledge and goes to ST_SKIP on a not-acknowledge. From any state, a start goes to ST_DEV and a stop goes to ST_IDLE. While the programming timer runs, the machine is held in ST_IDLE.

Top module: `eep_target`

## Requirements
- R1: A select byte is acknowledged (data pulled low during the ninth clock) only when its bits 7..1 equal 1010 followed by strap_i[2:0]. Any other select byte is not acknowledged, and the block stays silent until the next start or stop.
- R2: A select byte with bit 0 = 0, then a word-pointer byte, then a data byte, then a stop, stores the data at that pointer. A later read returns it.
- R3: During a write, only pointer bits 3..0 advance after each data byte. Bytes past the end of a 16-byte page wrap to the start of the same page.
- R4: A read (select bit 0 = 1) returns the byte at the pointer, and the full 8-bit pointer advances after each byte, wrapping from 0xFF to 0x00.
- R5: While wp_i is 1, data bytes aimed at 0x80..0xFF are acknowledged but not stored. Bytes aimed at 0x00..0x7F are always stored, and with wp_i at 0 the whole array is writable.
- R6: A stop that ends a write carrying at least one data byte starts a window of WR_CYCLES clocks. During the window no select byte is acknowledged and the data line is never pulled. After the window, select bytes are acknowledged again.
- R7: Pulses on either line that last fewer than FILT_HOLD filtered clock samples have no effect on received data.
- R8: Read data changes only after a falling clock edge and stays steady while the clock is high.
- R9: A start in the middle of a byte returns the block to select-byte reception. A stop in the middle of a byte returns it to idle. In both cases the partial byte is not stored, and no programming window starts.
- R10: After reset the data line is released and the block accepts a select byte at once.
- R11: After the host does not acknowledge a read byte, the block releases the data line and drives nothing until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| strap_i | input | 3 | Board-level select bits compared with select-byte bits 3..1 |
| wp_i | input | 1 | Protect input for pointer values 0x80..0xFF |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong state or bit count shows up at once on the data line. An acknowledge appears or goes missing on the ninth clock of the same byte, or read bits arrive shifted by a position, so the fault is visible within one byte time. A corrupted word pointer or a broken page wrap stays hidden until a later read. Such a read returns a byte that disagrees with the bench model, usually one transaction after the fault. A timer that runs too long or too short is exposed by the next address poll: the select byte gets an acknowledge where it should not, or no acknowledge where it should.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } eep_state_e;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;
endpackage

// File: rtl/eep_deglitch.sv
module eep_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(HOLD) + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   samp;

    assign samp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            run_q   <= '0;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (samp == clean_o) begin
                run_q <= '0;
            end else if (run_q == CW'(HOLD - 1)) begin
                clean_o <= samp;
                run_q   <= '0;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_req_i,
    input  logic              lock_hi_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic              commit;

    assign commit  = wr_req_i && !(lock_hi_i && addr_i[ADDR_W-1]);
    assign rdata_o = cells[addr_i];

    always_ff @(posedge clk) begin
        if (commit) begin
            cells[addr_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] left_q;

    assign busy_o = (left_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (go_i) begin
            left_q <= TW'(CYCLES);
        end else if (busy_o) begin
            left_q <= left_q - TW'(1);
        end
    end
endmodule

// File: rtl/eep_target.sv
module eep_target #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BITS   = 4,
    parameter int WR_CYCLES   = 1000,
    parameter int FILT_HOLD   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    import eep_pkg::*;

    localparam int BYTE_W = 8;

    eep_state_e        state;
    logic              scl_f, sda_f, scl_d, sda_d;
    logic              scl_rise, scl_fall, start_ev, stop_ev;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_full, rw_q, nack_q, dirty;
    logic [ADDR_W-1:0] waddr, page_next;
    logic [BYTE_W-1:0] rdata;
    logic              wr_req, busy, timer_go;

    eep_deglitch #(.SYNC_STAGES(SYNC_STAGES), .HOLD(FILT_HOLD)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f)
    );
    eep_deglitch #(.SYNC_STAGES(SYNC_STAGES), .HOLD(FILT_HOLD)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f)
    );

    eep_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
        .clk(clk), .wr_req_i(wr_req), .lock_hi_i(wp_i),
        .addr_i(waddr), .wdata_i(shreg), .rdata_o(rdata)
    );

    eep_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go_i(timer_go), .busy_o(busy)
    );

    assign scl_rise  = scl_f && !scl_d;
    assign scl_fall  = !scl_f && scl_d;
    assign start_ev  = scl_f && scl_d && sda_d && !sda_f;
    assign stop_ev   = scl_f && scl_d && !sda_d && sda_f;
    assign timer_go  = stop_ev && dirty && !busy;
    assign wr_req    = !busy && !start_ev && !stop_ev && (state == ST_WDAT)
                       && scl_fall && byte_full;
    assign page_next = {waddr[ADDR_W-1:PAGE_BITS],
                        waddr[PAGE_BITS-1:0] + PAGE_BITS'(1)};

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_full <= 1'b0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b0;
            waddr     <= '0;
            dirty     <= 1'b0;
            scl_d     <= 1'b1;
            sda_d     <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
            if (busy) begin
                state <= ST_IDLE;
                dirty <= 1'b0;
            end else if (start_ev) begin
                state     <= ST_DEV;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
            end else if (stop_ev) begin
                state     <= ST_IDLE;
                byte_full <= 1'b0;
                dirty     <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_SKIP: begin
                    end
                    ST_DEV, ST_WADR, ST_WDAT: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) byte_full <= 1'b1;
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            bit_cnt   <= '0;
                            if (state == ST_DEV) begin
                                if (shreg[7:1] == {DEV_FAMILY, strap_i}) begin
                                    rw_q  <= shreg[0];
                                    state <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_WADR) begin
                                waddr <= shreg[ADDR_W-1:0];
                                state <= ST_WADR_ACK;
                            end else begin
                                waddr <= page_next;
                                dirty <= 1'b1;
                                state <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                shreg <= rdata;
                                waddr <= waddr + ADDR_W'(1);
                                state <= ST_RDAT;
                            end else begin
                                state <= ST_WADR;
                            end
                        end
                    end
                    ST_WADR_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) state <= ST_WDAT;
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) state <= ST_RACK;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_f;
                        end else if (scl_fall) begin
                            if (!nack_q) begin
                                shreg   <= rdata;
                                waddr   <= waddr + ADDR_W'(1);
                                bit_cnt <= '0;
                                state   <= ST_RDAT;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
            ST_RDAT:                              sda_oe_o = !shreg[BYTE_W-1];
            default:                              sda_oe_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/eep_target_chk.sv
module eep_target_chk #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_f,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              busy,
    input logic              sda_oe,
    input logic              wr_req,
    input logic [ADDR_W-1:0] waddr
);
    assert_quiet_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    assert_busy_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_ev));

    assert_steady_while_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

    assert_page_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (waddr[ADDR_W-1:PAGE_BITS] == $past(waddr[ADDR_W-1:PAGE_BITS])));
endmodule

bind eep_target eep_target_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_ev(start_ev), .stop_ev(stop_ev),
    .busy(busy), .sda_oe(sda_oe_o), .wr_req(wr_req), .waddr(waddr)
);

// File: tb/eep_target_tb.sv
module eep_target_tb_top;
    localparam int WRC = 600;
    localparam int Q   = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    wire  bus_sda = m_sda & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] model [256];
    bit         known [256];
    logic [7:0] wbuf  [32];

    always #2 clk = ~clk;

    eep_target #(.WR_CYCLES(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] page_addr(input logic [7:0] base, input int k);
        logic [3:0] lo;
        lo = base[3:0] + 4'(k);
        return {base[7:4], lo};
    endfunction

    task automatic t_start;
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic t_stop;
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic t_bit_out(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    // Bit 3 optionally carries short pulses on both lines
    task automatic t_send(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            if (glitch && i == 3) begin
                m_sda = b[i]; tick(Q / 2);
                m_scl = 1'b1; tick(2);
                m_scl = 1'b0; tick(Q / 2 - 2);
                m_scl = 1'b1; tick(Q);
                m_sda = ~b[i]; tick(2);
                m_sda = b[i]; tick(Q - 2);
                m_scl = 1'b0; tick(Q);
            end else begin
                t_bit_out(b[i]);
            end
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = !bus_sda;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic t_recv(input bit host_ack, output logic [7:0] b, output bit steady);
        logic s1, s2;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(1);
            s1 = bus_sda;
            tick(2 * Q - 2);
            s2 = bus_sda;
            if (s1 != s2) steady = 1'b0;
            b[i] = s2;
            tick(1);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = !host_ack; tick(Q);
        m_scl = 1'b1;      tick(2 * Q);
        m_scl = 1'b0;      tick(Q);
    endtask

    task automatic write_seq(input logic [7:0] a, input int n, input string req);
        bit ak;
        t_start;
        t_send(DEV_W, 1'b0, ak); chk(req, ak, 1);
        t_send(a, 1'b0, ak);     chk(req, ak, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] pa;
            t_send(wbuf[k], 1'b0, ak);
            chk(req, ak, 1);
            pa = page_addr(a, k);
            if (!(wp && pa[7])) begin
                model[pa] = wbuf[k];
                known[pa] = 1'b1;
            end
        end
        t_stop;
        tick(WRC + 20);
    endtask

    task automatic read_seq(input logic [7:0] a, input int n, input string req);
        bit ak, st;
        logic [7:0] got;
        logic [7:0] pa;
        t_start;
        t_send(DEV_W, 1'b0, ak); chk(req, ak, 1);
        t_send(a, 1'b0, ak);     chk(req, ak, 1);
        t_start;
        t_send(DEV_R, 1'b0, ak); chk(req, ak, 1);
        for (int k = 0; k < n; k++) begin
            t_recv(k != n - 1, got, st);
            chk("R8", st, 1);
            pa = a + 8'(k);
            if (known[pa]) chk(req, got, model[pa]);
        end
        t_stop;
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up;
    end

    initial begin
        bit ak, st;
        logic [7:0] got;
        for (int i = 0; i < 256; i++) known[i] = 1'b0;
        void'($urandom(32'd20240611));
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R10: released after reset and ready for a select byte at once
        chk("R10", bus_sda, 1);
        t_start;
        t_send(DEV_W, 1'b0, ak); chk("R10", ak, 1);
        t_stop;

        // R1: wrong strap bits and wrong family code get no acknowledge
        t_start;
        t_send({4'b1010, 3'b100, 1'b0}, 1'b0, ak); chk("R1", ak, 0);
        t_stop;
        t_start;
        t_send({4'b1011, STRAP, 1'b0}, 1'b0, ak); chk("R1", ak, 0);
        t_stop;

        // R2: single byte write and read-back
        wbuf[0] = 8'h5A;
        write_seq(8'h10, 1, "R2");
        read_seq(8'h10, 1, "R2");

        // R3: page write from 0x3C wraps to 0x30
        for (int k = 0; k < 6; k++) wbuf[k] = 8'hC0 + 8'(k);
        write_seq(8'h3C, 6, "R3");
        read_seq(8'h30, 2, "R3");
        read_seq(8'h3C, 4, "R3");
        chk("R3", model[8'h30], 8'hC4);

        // R5: protected upper half
        wbuf[0] = 8'h33;
        write_seq(8'h90, 1, "R5");
        wp = 1'b1;
        wbuf[0] = 8'h77;
        write_seq(8'h90, 1, "R5");
        wbuf[0] = 8'h44;
        write_seq(8'h20, 1, "R5");
        read_seq(8'h90, 1, "R5");
        read_seq(8'h20, 1, "R5");
        chk("R5", model[8'h90], 8'h33);
        wp = 1'b0;
        wbuf[0] = 8'h99;
        write_seq(8'h90, 1, "R5");
        read_seq(8'h90, 1, "R5");

        // R6: programming window blocks the select byte
        t_start;
        t_send(DEV_W, 1'b0, ak);
        t_send(8'h70, 1'b0, ak);
        t_send(8'hA5, 1'b0, ak);
        t_stop;
        model[8'h70] = 8'hA5; known[8'h70] = 1'b1;
        t_start;
        t_send(DEV_W, 1'b0, ak); chk("R6", ak, 0);
        t_stop;
        tick(WRC);
        t_start;
        t_send(DEV_W, 1'b0, ak); chk("R6", ak, 1);
        t_stop;
        read_seq(8'h70, 1, "R6");

        // R4: sequential read wraps 0xFF to 0x00
        wbuf[0] = 8'h1E; wbuf[1] = 8'h1F;
        write_seq(8'hFE, 2, "R4");
        wbuf[0] = 8'h20;
        write_seq(8'h00, 1, "R4");
        read_seq(8'hFE, 3, "R4");

        // R9: start in the middle of a data byte
        wbuf[0] = 8'h11;
        write_seq(8'h50, 1, "R9");
        t_start;
        t_send(DEV_W, 1'b0, ak);
        t_send(8'h50, 1'b0, ak);
        t_bit_out(1'b1); t_bit_out(1'b1); t_bit_out(1'b1); t_bit_out(1'b0);
        t_start;
        t_send(DEV_R, 1'b0, ak); chk("R9", ak, 1);
        t_recv(1'b0, got, st);   chk("R9", got, 8'h11);
        t_stop;
        // R9: stop in the middle of a data byte, no window follows
        wbuf[0] = 8'h22;
        write_seq(8'h51, 1, "R9");
        t_start;
        t_send(DEV_W, 1'b0, ak);
        t_send(8'h51, 1'b0, ak);
        t_bit_out(1'b1); t_bit_out(1'b1); t_bit_out(1'b0);
        t_stop;
        t_start;
        t_send(DEV_W, 1'b0, ak); chk("R9", ak, 1);
        t_stop;
        read_seq(8'h51, 1, "R9");

        // R11: after a host not-acknowledge the line stays released
        t_start;
        t_send(DEV_W, 1'b0, ak);
        t_send(8'h10, 1'b0, ak);
        t_start;
        t_send(DEV_R, 1'b0, ak);
        t_recv(1'b0, got, st); chk("R11", got, 8'h5A);
        t_recv(1'b0, got, st); chk("R11", got, 8'hFF);
        t_stop;

        // R7: short pulses on both lines inside a data byte
        t_start;
        t_send(DEV_W, 1'b0, ak);
        t_send(8'h60, 1'b0, ak);
        t_send(8'h3C, 1'b1, ak); chk("R7", ak, 1);
        t_send(8'hC3, 1'b1, ak); chk("R7", ak, 1);
        t_stop;
        model[8'h60] = 8'h3C; known[8'h60] = 1'b1;
        model[8'h61] = 8'hC3; known[8'h61] = 1'b1;
        tick(WRC + 20);
        read_seq(8'h60, 2, "R7");

        // Random page writes and sequential reads against the model
        for (int it = 0; it < 8; it++) begin
            logic [7:0] a;
            int n;
            wp = 1'($urandom % 2);
            a  = 8'($urandom);
            n  = 1 + int'($urandom % 18);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            write_seq(a, n, "R3");
            wp = 1'b0;
            a  = 8'($urandom);
            read_seq(a, 1 + int'($urandom % 8), "R4");
            read_seq({a[7:4], 4'h0}, 16, "R5");
        end

        finish_up;
    end
endmodule